// File: doc/BRIEF.md
# Automatic Level Control Gain Controller

This block steers the 6-bit gain code of a microphone preamplifier so that the recorded level stays inside a programmable window. Each PCM sample from the converter path is classified as loud, quiet, in-window or, when the gate is armed, below the noise floor. A loud signal pulls the gain down straight away at the attack rate. A quiet signal first waits out a hold interval and then pushes the gain up at the slower decay rate. A limiter mode swaps in a second, faster pair of attack and decay rates. Every step is exactly one code (0.75 dB) and stays between a programmable floor and ceiling. Code 0 is -12 dB and code 63 is +35.25 dB.

All intervals are counted in master-clock cycles. A step interval is a base count shifted left by its 4-bit code, so the time doubles per code. Gain steps can be restricted to zero crossings, meaning samples whose sign differs from the one before. A sample-count timeout stops a pending step from waiting forever. A noise gate freezes the gain and raises a flag. With the enable cleared, the gain stays where it is.

The control is a five-state machine. IDLE means in-window. HOLD means quiet and waiting. RAISE means quiet and stepping up. LOWER means loud and stepping down. GATE means gated. On any change of the latched sample class, every state jumps straight to the entry state of the new class: loud goes to LOWER, quiet goes to HOLD (or to RAISE when the hold code is 0), gated goes to GATE, and in-window goes to IDLE. HOLD moves to RAISE when its hold interval runs out. Clearing the enable sends every state to IDLE.

Top module: `alc_gain_ctrl`

## Requirements
- R1: After reset, gain_code is GAIN_RST (16, which is 0 dB) and gate_active is 0.
- R2: With T = target_lvl, let hi = (T+1)·2^(SW-5) and lo = hi/2. A sample with magnitude > hi is loud, a sample with magnitude < lo is quiet, and anything from lo to hi inclusive leaves the gain unchanged.
- R3: After a loud sample latched at edge k, the gain drops by 1 at edge k+1+A and again every A cycles, where A = ATK_BASE << attack_sel. No hold delay is applied to a decrease.
- R4: After a quiet sample latched at edge k, the first rise comes at edge k+1+H+D and later rises every D cycles. D = DCY_BASE << decay_sel. H = 0 when hold_sel is 0, otherwise HOLD_BASE << (hold_sel-1).
- R5: With lim_mode = 1, ATK_BASE_LIM and DCY_BASE_LIM replace ATK_BASE and DCY_BASE.
- R6: The gain never rises above the ceiling 8·max_sel+7.
- R7: The gain never falls below the floor 8·min_sel.
- R8: Every gain change is exactly +1 or -1 code.
- R9: With gate_en = 1, a sample whose magnitude is below (gate_thr+1)·2^(SW-9) takes priority over quiet. gate_active rises one cycle after that sample, and the gain stays frozen while gate_active is 1.
- R10: With zc_en = 1, a due step is applied only at the edge of a sample whose sign bit differs from the previous sample's sign bit.
- R11: With zc_en = 1, a pending step is forced on the ZC_TIMEOUT-th sample after it became due if no crossing has occurred.
- R12: With alc_en = 0, gain_code holds its value and gate_active is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all intervals are counted in its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| alc_en | input | 1 | Enables level control |
| lim_mode | input | 1 | 1 selects the limiter timing pair |
| zc_en | input | 1 | Restricts gain steps to zero crossings |
| gate_en | input | 1 | Arms the noise gate |
| gate_thr | input | 3 | Noise gate threshold select |
| target_lvl | input | 4 | Target window select |
| max_sel | input | 3 | Gain ceiling select |
| min_sel | input | 3 | Gain floor select |
| hold_sel | input | 4 | Hold interval code |
| attack_sel | input | 4 | Attack step interval code |
| decay_sel | input | 4 | Decay step interval code |
| sample_valid | input | 1 | One-cycle strobe marking a new sample |
| sample_in | input | SW | Signed two's-complement PCM sample |
| gain_code | output | 6 | Preamplifier gain code |
| gate_active | output | 1 | High while the noise gate holds the gain |

## Verification
A sample is latched at edge k and the state machine reacts at edge k+1. The first decrease is therefore due 1+A cycles after the sample edge, and the first increase 1+H+D cycles after it; later steps follow every A or D cycles. The bench counts falling edges from the sample edge until gain_code moves, and compares that count with these sums computed from the base counts and codes. gate_active is due one cycle after its sample. A zero-crossing step lands on the very sample edge, so it is sampled at the falling edge just after it. The limit and window checks wait well past the longest interval before they compare.

// File: rtl/alc_pkg.sv
package alc_pkg;
    typedef enum logic [1:0] {
        LV_OK    = 2'd0,
        LV_LOUD  = 2'd1,
        LV_QUIET = 2'd2,
        LV_GATE  = 2'd3
    } level_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HOLD  = 3'd1,
        ST_RAISE = 3'd2,
        ST_LOWER = 3'd3,
        ST_GATE  = 3'd4
    } alc_state_e;
endpackage

// File: rtl/alc_level_detect.sv
module alc_level_detect
    import alc_pkg::*;
#(
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample_valid,
    input  logic [SW-1:0] sample_in,
    input  logic [3:0]    target_lvl,
    input  logic          gate_en,
    input  logic [2:0]    gate_thr,
    output level_e        level,
    output logic          zc_hit
);
    localparam int MW = SW + 1;

    logic [MW-1:0] ext_s, mag, hi_lvl, lo_lvl, gate_lvl;
    level_e        lvl_next, level_q;
    logic          sign_q;

    always_comb begin
        ext_s    = {sample_in[SW-1], sample_in};
        mag      = ext_s[MW-1] ? (~ext_s + MW'(1)) : ext_s;
        hi_lvl   = (MW'(target_lvl) + MW'(1)) << (SW - 5);
        lo_lvl   = hi_lvl >> 1;
        gate_lvl = (MW'(gate_thr) + MW'(1)) << (SW - 9);
        if (gate_en && (mag < gate_lvl))
            lvl_next = LV_GATE;
        else if (mag > hi_lvl)
            lvl_next = LV_LOUD;
        else if (mag < lo_lvl)
            lvl_next = LV_QUIET;
        else
            lvl_next = LV_OK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= LV_OK;
            sign_q  <= 1'b0;
        end else if (sample_valid) begin
            level_q <= lvl_next;
            sign_q  <= sample_in[SW-1];
        end
    end

    assign level  = level_q;
    assign zc_hit = sample_in[SW-1] ^ sign_q;

    AST_GATE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && !gate_en) |=> (level != LV_GATE)); // R9
endmodule

// File: rtl/alc_step_timer.sv
module alc_step_timer
    import alc_pkg::*;
#(
    parameter int CW           = 32,
    parameter int HOLD_BASE    = 32768,
    parameter int ATK_BASE     = 1275,
    parameter int DCY_BASE     = 5069,
    parameter int ATK_BASE_LIM = 276,
    parameter int DCY_BASE_LIM = 1121
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       alc_en,
    input  logic       lim_mode,
    input  level_e     level,
    input  logic [3:0] hold_sel,
    input  logic [3:0] attack_sel,
    input  logic [3:0] decay_sel,
    output logic       fire_up,
    output logic       fire_dn,
    output logic       ramping,
    output logic       in_gate
);
    alc_state_e    st_q, st_next, entry_st;
    logic [CW-1:0] cnt_q, atk_iv, dcy_iv, hold_iv;
    logic          hold_done;

    always_comb begin
        atk_iv  = (lim_mode ? CW'(ATK_BASE_LIM) : CW'(ATK_BASE)) << attack_sel;
        dcy_iv  = (lim_mode ? CW'(DCY_BASE_LIM) : CW'(DCY_BASE)) << decay_sel;
        hold_iv = (hold_sel == 4'd0) ? '0 : (CW'(HOLD_BASE) << (hold_sel - 4'd1));
        hold_done = (cnt_q == hold_iv - CW'(1));
    end

    always_comb begin
        unique case (level)
            LV_LOUD:  entry_st = ST_LOWER;
            LV_QUIET: entry_st = (hold_sel == 4'd0) ? ST_RAISE : ST_HOLD;
            LV_GATE:  entry_st = ST_GATE;
            default:  entry_st = ST_IDLE;
        endcase
    end

    always_comb begin
        st_next = st_q;
        if (!alc_en) begin
            st_next = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:  if (level != LV_OK) st_next = entry_st;
                ST_HOLD: begin
                    if (level != LV_QUIET) st_next = entry_st;
                    else if (hold_done)    st_next = ST_RAISE;
                end
                ST_RAISE: if (level != LV_QUIET) st_next = entry_st;
                ST_LOWER: if (level != LV_LOUD)  st_next = entry_st;
                ST_GATE:  if (level != LV_GATE)  st_next = entry_st;
                default:  st_next = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_next;
    end

    always_comb begin
        fire_up = (st_q == ST_RAISE) && (st_next == ST_RAISE) && (cnt_q == dcy_iv - CW'(1));
        fire_dn = (st_q == ST_LOWER) && (st_next == ST_LOWER) && (cnt_q == atk_iv - CW'(1));
        ramping = (st_q == ST_RAISE) || (st_q == ST_LOWER);
        in_gate = (st_q == ST_GATE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if ((st_next != st_q) || fire_up || fire_dn || (st_q == ST_IDLE) || (st_q == ST_GATE))
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CW'(1);
    end

    AST_RAISE_ONLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        fire_up |-> (level == LV_QUIET && alc_en)); // R4
    AST_LOWER_ONLY_LOUD: assert property (@(posedge clk) disable iff (!rst_n)
        fire_dn |-> (level == LV_LOUD && alc_en)); // R3
    AST_GATE_CLEARS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !alc_en |=> !in_gate); // R12
endmodule

// File: rtl/alc_gain_reg.sv
module alc_gain_reg #(
    parameter int GAIN_RST   = 16,
    parameter int ZC_TIMEOUT = 65536
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       alc_en,
    input  logic       ramping,
    input  logic       fire_up,
    input  logic       fire_dn,
    input  logic       zc_en,
    input  logic       sample_valid,
    input  logic       zc_hit,
    input  logic [2:0] max_sel,
    input  logic [2:0] min_sel,
    output logic [5:0] gain_code
);
    localparam int ZW = $clog2(ZC_TIMEOUT + 1);

    logic [5:0]    gain_q, max_g, min_g;
    logic          pend_up_q, pend_dn_q, zc_go, do_up, do_dn, active;
    logic [ZW-1:0] zc_cnt_q;

    always_comb begin
        max_g  = {max_sel, 3'b111};
        min_g  = {min_sel, 3'b000};
        active = alc_en && ramping;
        zc_go  = sample_valid && (zc_hit || (zc_cnt_q == ZW'(ZC_TIMEOUT - 1)));
        do_up  = active && ((fire_up && !zc_en) || (pend_up_q && zc_en && zc_go));
        do_dn  = active && ((fire_dn && !zc_en) || (pend_dn_q && zc_en && zc_go));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_up_q <= 1'b0;
            pend_dn_q <= 1'b0;
            zc_cnt_q  <= '0;
        end else if (!active) begin
            pend_up_q <= 1'b0;
            pend_dn_q <= 1'b0;
            zc_cnt_q  <= '0;
        end else begin
            if ((pend_up_q || pend_dn_q) && zc_go) begin
                pend_up_q <= 1'b0;
                pend_dn_q <= 1'b0;
                zc_cnt_q  <= '0;
            end else if ((pend_up_q || pend_dn_q) && sample_valid) begin
                zc_cnt_q <= zc_cnt_q + ZW'(1);
            end
            if (fire_up && zc_en) begin
                pend_up_q <= 1'b1;
                pend_dn_q <= 1'b0;
            end else if (fire_dn && zc_en) begin
                pend_up_q <= 1'b0;
                pend_dn_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            gain_q <= 6'(GAIN_RST);
        else if (do_up && (gain_q < max_g))
            gain_q <= gain_q + 6'd1;
        else if (do_dn && (gain_q > min_g))
            gain_q <= gain_q - 6'd1;
    end

    assign gain_code = gain_q;

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_q == $past(gain_q)) || (gain_q == $past(gain_q) + 6'd1) || (gain_q == $past(gain_q) - 6'd1)); // R8
    AST_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_q > $past(gain_q)) |-> (gain_q <= {$past(max_sel), 3'b111})); // R6
    AST_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_q < $past(gain_q)) |-> (gain_q >= {$past(min_sel), 3'b000})); // R7
    AST_ZC_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(zc_en) && (gain_q != $past(gain_q))) |-> $past(sample_valid)); // R10
    AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !alc_en |=> $stable(gain_q)); // R12
endmodule

// File: rtl/alc_gain_ctrl.sv
module alc_gain_ctrl
    import alc_pkg::*;
#(
    parameter int SW           = 16,
    parameter int CW           = 32,
    parameter int HOLD_BASE    = 32768,
    parameter int ATK_BASE     = 1275,
    parameter int DCY_BASE     = 5069,
    parameter int ATK_BASE_LIM = 276,
    parameter int DCY_BASE_LIM = 1121,
    parameter int ZC_TIMEOUT   = 65536,
    parameter int GAIN_RST     = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alc_en,
    input  logic          lim_mode,
    input  logic          zc_en,
    input  logic          gate_en,
    input  logic [2:0]    gate_thr,
    input  logic [3:0]    target_lvl,
    input  logic [2:0]    max_sel,
    input  logic [2:0]    min_sel,
    input  logic [3:0]    hold_sel,
    input  logic [3:0]    attack_sel,
    input  logic [3:0]    decay_sel,
    input  logic          sample_valid,
    input  logic [SW-1:0] sample_in,
    output logic [5:0]    gain_code,
    output logic          gate_active
);
    level_e level;
    logic   zc_hit, fire_up, fire_dn, ramping, in_gate;

    alc_level_detect #(.SW(SW)) u_detect (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample_in(sample_in),
        .target_lvl(target_lvl), .gate_en(gate_en), .gate_thr(gate_thr),
        .level(level), .zc_hit(zc_hit)
    );

    alc_step_timer #(
        .CW(CW), .HOLD_BASE(HOLD_BASE), .ATK_BASE(ATK_BASE), .DCY_BASE(DCY_BASE),
        .ATK_BASE_LIM(ATK_BASE_LIM), .DCY_BASE_LIM(DCY_BASE_LIM)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .alc_en(alc_en), .lim_mode(lim_mode), .level(level),
        .hold_sel(hold_sel), .attack_sel(attack_sel), .decay_sel(decay_sel),
        .fire_up(fire_up), .fire_dn(fire_dn), .ramping(ramping), .in_gate(in_gate)
    );

    alc_gain_reg #(.GAIN_RST(GAIN_RST), .ZC_TIMEOUT(ZC_TIMEOUT)) u_gain (
        .clk(clk), .rst_n(rst_n), .alc_en(alc_en), .ramping(ramping),
        .fire_up(fire_up), .fire_dn(fire_dn), .zc_en(zc_en),
        .sample_valid(sample_valid), .zc_hit(zc_hit),
        .max_sel(max_sel), .min_sel(min_sel), .gain_code(gain_code)
    );

    assign gate_active = in_gate;

    AST_GATE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        gate_active |=> $stable(gain_code)); // R9
endmodule

// File: tb/tb_alc_gain_ctrl.sv
module tb_alc_gain_ctrl;
    localparam int SW  = 16;
    localparam int HB  = 3;
    localparam int AB  = 2;
    localparam int DB  = 5;
    localparam int ABL = 1;
    localparam int DBL = 3;
    localparam int ZT  = 8;
    localparam int GR  = 16;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          alc_en = 1'b1, lim_mode = 1'b0, zc_en = 1'b0, gate_en = 1'b0;
    logic [2:0]    gate_thr = 3'd0, max_sel = 3'd7, min_sel = 3'd0;
    logic [3:0]    target_lvl = 4'd7, hold_sel = 4'd0, attack_sel = 4'd0, decay_sel = 4'd0;
    logic          sample_valid = 1'b0;
    logic [SW-1:0] sample_in = '0;
    logic [5:0]    gain_code;
    logic          gate_active;
    int            checks = 0, errors = 0;

    alc_gain_ctrl #(
        .SW(SW), .CW(32), .HOLD_BASE(HB), .ATK_BASE(AB), .DCY_BASE(DB),
        .ATK_BASE_LIM(ABL), .DCY_BASE_LIM(DBL), .ZC_TIMEOUT(ZT), .GAIN_RST(GR)
    ) dut (
        .clk(clk), .rst_n(rst_n), .alc_en(alc_en), .lim_mode(lim_mode), .zc_en(zc_en),
        .gate_en(gate_en), .gate_thr(gate_thr), .target_lvl(target_lvl),
        .max_sel(max_sel), .min_sel(min_sel), .hold_sel(hold_sel),
        .attack_sel(attack_sel), .decay_sel(decay_sel), .sample_valid(sample_valid),
        .sample_in(sample_in), .gain_code(gain_code), .gate_active(gate_active)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic send(input int v);
        @(negedge clk);
        sample_in    = SW'(v);
        sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic settle(input int mid);
        send(mid);
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_change(output int n);
        logic [5:0] g0;
        g0 = gain_code;
        n  = 0;
        while (gain_code == g0 && n < 3000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int n;
        int iv_a, iv_d, iv_h;
        logic [5:0] g0;
        repeat (3) @(negedge clk);
        check(gain_code == 6'(GR), "R1 reset gain", gain_code, GR);
        check(gate_active == 1'b0, "R1 reset gate", gate_active, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 R4 R5: interval sweeps in both timing modes
        for (int lm = 0; lm < 2; lm++) begin
            for (int c = 0; c < 5; c++) begin
                lim_mode   = lm[0];
                attack_sel = 4'(c);
                decay_sel  = 4'(c);
                hold_sel   = 4'(c);
                iv_a = (lm != 0 ? ABL : AB) << c;
                iv_d = (lm != 0 ? DBL : DB) << c;
                iv_h = (c == 0) ? 0 : (HB << (c - 1));
                settle(12000);
                g0 = gain_code;
                send(20000);
                wait_change(n);
                check(n == iv_a + 1, lm != 0 ? "R5 R3 first attack" : "R3 first attack", n, iv_a + 1);
                check(gain_code == g0 - 6'd1, "R8 attack step", gain_code, g0 - 1);
                wait_change(n);
                check(n == iv_a, "R3 repeat attack", n, iv_a);
                settle(12000);
                g0 = gain_code;
                send(4000);
                wait_change(n);
                check(n == 1 + iv_h + iv_d, lm != 0 ? "R5 R4 first decay" : "R4 first decay", n, 1 + iv_h + iv_d);
                check(gain_code == g0 + 6'd1, "R8 decay step", gain_code, g0 + 1);
                wait_change(n);
                check(n == iv_d, "R4 repeat decay", n, iv_d);
            end
        end
        lim_mode = 1'b0; attack_sel = 4'd0; decay_sel = 4'd0; hold_sel = 4'd0;

        // R6: ceiling sweep
        for (int m = 0; m < 8; m++) begin
            max_sel = 3'(m); min_sel = 3'd0;
            send(20000);
            repeat (200) @(negedge clk);
            check(gain_code == 6'd0, "R7 floor zero", gain_code, 0);
            send(4000);
            repeat (400) @(negedge clk);
            check(gain_code == 6'(8 * m + 7), "R6 ceiling", gain_code, 8 * m + 7);
        end
        // R7: floor sweep
        max_sel = 3'd7;
        for (int f = 0; f < 8; f++) begin
            min_sel = 3'(f);
            send(4000);
            repeat (400) @(negedge clk);
            check(gain_code == 6'd63, "R6 top", gain_code, 63);
            send(20000);
            repeat (200) @(negedge clk);
            check(gain_code == 6'(8 * f), "R7 floor", gain_code, 8 * f);
        end
        min_sel = 3'd0;

        // R2: window edges for each target
        for (int t = 0; t < 15; t++) begin
            int hi, lo, mid;
            target_lvl = 4'(t);
            hi = (t + 1) * 2048; lo = hi / 2; mid = (hi + lo) / 2;
            settle(mid);
            g0 = gain_code;
            send(hi);
            repeat (30) @(negedge clk);
            check(gain_code == g0, "R2 upper edge inside", gain_code, g0);
            send(hi + 1);
            repeat (3) @(negedge clk);
            check(gain_code == g0 - 6'd1, "R2 above upper edge", gain_code, g0 - 1);
            settle(mid);
            g0 = gain_code;
            send(lo);
            repeat (30) @(negedge clk);
            check(gain_code == g0, "R2 lower edge inside", gain_code, g0);
            send(lo - 1);
            repeat (6) @(negedge clk);
            check(gain_code == g0 + 6'd1, "R2 below lower edge", gain_code, g0 + 1);
        end
        target_lvl = 4'd7;

        // R9: noise gate with threshold 128
        settle(12000);
        gate_en = 1'b1; gate_thr = 3'd0;
        g0 = gain_code;
        send(127);
        check(gate_active == 1'b0, "R9 gate not yet", gate_active, 0);
        @(negedge clk);
        check(gate_active == 1'b1, "R9 gate raised", gate_active, 1);
        repeat (200) @(negedge clk);
        check(gain_code == g0, "R9 gain frozen", gain_code, g0);
        send(128);
        wait_change(n);
        check(n == 1 + DB, "R9 threshold edge is quiet", n, 1 + DB);
        check(gate_active == 1'b0, "R9 gate released", gate_active, 0);
        send(-100);
        @(negedge clk);
        check(gate_active == 1'b1, "R9 negative gated", gate_active, 1);
        gate_en = 1'b0;
        settle(12000);

        // R12: disabled holds gain
        alc_en = 1'b0;
        g0 = gain_code;
        send(20000);
        repeat (300) @(negedge clk);
        check(gain_code == g0, "R12 frozen loud", gain_code, g0);
        gate_en = 1'b1;
        send(10);
        repeat (5) @(negedge clk);
        check(gate_active == 1'b0, "R12 gate low", gate_active, 1'b0);
        gate_en = 1'b0;
        settle(12000);
        alc_en = 1'b1;
        repeat (3) @(negedge clk);

        // R10: zero-crossing
        zc_en = 1'b1; attack_sel = 4'd5;
        settle(12000);
        g0 = gain_code;
        send(20000);
        repeat (80) @(negedge clk);
        check(gain_code == g0, "R10 waits for crossing", gain_code, g0);
        for (int i = 0; i < 3; i++) send(20000);
        check(gain_code == g0, "R10 same sign no step", gain_code, g0);
        send(-20000);
        check(gain_code == g0 - 6'd1, "R10 step at crossing", gain_code, g0 - 1);

        // R11: timeout
        settle(12000);
        send(20000);
        repeat (70) @(negedge clk);
        g0 = gain_code;
        for (int i = 0; i < ZT - 1; i++) send(20000);
        check(gain_code == g0, "R11 before timeout", gain_code, g0);
        send(20000);
        check(gain_code == g0 - 6'd1, "R11 forced at timeout", gain_code, g0 - 1);
        zc_en = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule